// File: doc/BRIEF.md
# Burst SRAM Access Control Front-End

This block holds the per-clock access control of a synchronous pipelined SRAM with a shared data bus. On every rising edge it samples three chip selects, two address strobes, a global write, a byte-write enable and one write enable per byte lane. From these it classifies the cycle as idle, deselect, read start, write start, or a continuation at the held address. One strobe comes from the processor side and the other from the memory controller side. The processor strobe always takes priority.

A start cycle loads the address register. A write cycle produces per-lane write strobes into a behavioural storage array. A read cycle registers the addressed word, so data appears one clock after the read. Each byte lane has a tri-state enable. It is formed from the asynchronous output-enable input, which is masked whenever the current inputs decode a write. Burst address stepping and power-down handling live in other blocks. Continuation cycles therefore reuse the held address unchanged.

Top module: `burst_sram_front`

## Requirements
- R1: The device is selected only when ce1N=0, ce2=1 and ce3N=0. A cycle with either strobe low while not selected is a deselect: no array access, the access session ends, and on the next clock all byteOe bits are 0.
- R2: With procStrobeN=0 and the device selected, the cycle is a read start at addrIn, whatever gwN, bweN and bwN are. dataOut shows the addressed word after the following rising edge.
- R3: When procStrobeN=0, ctlStrobeN has no effect: the cycle is decoded exactly as with ctlStrobeN=1 plus a processor strobe.
- R4: With procStrobeN=1, ctlStrobeN=0, the device selected and the write term active, the word at addrIn is written from dataIn on that edge. With the write term inactive, the cycle is a read start instead.
- R5: The write term is active when gwN=0, or when bweN=0 and at least one bwN bit is 0. gwN=0 writes every lane.
- R6: Lane i is data bits [8i+7:8i] and is written only when gwN=0 or (bweN=0 and bwN[i]=0). Unwritten lanes keep their stored contents.
- R7: After an accepted start, a cycle with both strobes high is a continuation at the held address. It is a write if the write term is active and a read otherwise; chip selects are not looked at. With no session, such a cycle does nothing.
- R8: The address register changes only on a read or write start. Continuation cycles use it even while addrIn changes.
- R9: byteOe is all ones only when the previous clock was a read cycle, oeN=0, and the current inputs do not decode a write. Otherwise it is all zeros. oeN acts without a clock.
- R10: During and right after reset there is no session and byteOe is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| ce1N | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3N | input | 1 | Chip select, active low |
| procStrobeN | input | 1 | Processor address strobe, active low, priority |
| ctlStrobeN | input | 1 | Controller address strobe, active low |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | NUM_BYTES | Per-lane write enables, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| addrIn | input | ADDR_W | Address presented with a strobe |
| dataIn | input | NUM_BYTES*BYTE_W | Write data |
| dataOut | output | NUM_BYTES*BYTE_W | Registered read data |
| byteOe | output | NUM_BYTES | Per-lane bus drive enable |

## Verification
The assertions assume that every control input is a known 0 or 1 at each rising edge. They also assume that oeN does not change between the check point and the edge it is sampled at. The stimulus drives every input at the falling edge only and never drives X or Z. The array is filled by a full sweep of global writes before any read, so every read the reference model predicts has a defined value. Random cycles are weighted toward continuations and partial lane masks, which exercises the held address and the lane gating often.

// File: rtl/sram_fe_pkg.sv
package sram_fe_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_READ_START,
    CYC_WRITE_START,
    CYC_CONT_READ,
    CYC_CONT_WRITE
  } cycle_e;

  typedef struct packed {
    logic loadAddr;
    logic doRead;
    logic doWrite;
  } strobes_t;

endpackage

// File: rtl/sram_fe_ctl.sv
module sram_fe_ctl
  import sram_fe_pkg::*;
#(
  parameter int NUM_BYTES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ce1N,
  input  logic                 ce2,
  input  logic                 ce3N,
  input  logic                 procStrobeN,
  input  logic                 ctlStrobeN,
  input  logic                 gwN,
  input  logic                 bweN,
  input  logic [NUM_BYTES-1:0] bwN,
  output strobes_t             str,
  output logic [NUM_BYTES-1:0] byteWe
);

  logic                 selected;
  logic                 writeTerm;
  logic                 sessionActive;
  logic [NUM_BYTES-1:0] laneWrite;
  cycle_e               kind;

  assign selected  = !ce1N && ce2 && !ce3N;
  assign writeTerm = !gwN || (!bweN && (|(~bwN)));

  // Priority: processor strobe, then controller strobe, then continuation
  always_comb begin
    if (!procStrobeN) begin
      kind = selected ? CYC_READ_START : CYC_DESEL;
    end else if (!ctlStrobeN) begin
      if (!selected)      kind = CYC_DESEL;
      else if (writeTerm) kind = CYC_WRITE_START;
      else                kind = CYC_READ_START;
    end else if (sessionActive) begin
      kind = writeTerm ? CYC_CONT_WRITE : CYC_CONT_READ;
    end else begin
      kind = CYC_IDLE;
    end
  end

  always_comb begin
    str.loadAddr = (kind == CYC_READ_START) || (kind == CYC_WRITE_START);
    str.doRead   = (kind == CYC_READ_START) || (kind == CYC_CONT_READ);
    str.doWrite  = (kind == CYC_WRITE_START) || (kind == CYC_CONT_WRITE);
  end

  for (genvar i = 0; i < NUM_BYTES; i++) begin : gLane
    assign laneWrite[i] = !gwN || (!bweN && !bwN[i]);
    assign byteWe[i]    = str.doWrite && laneWrite[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sessionActive <= 1'b0;
    end else if (kind == CYC_DESEL) begin
      sessionActive <= 1'b0;
    end else if (str.loadAddr) begin
      sessionActive <= 1'b1;
    end
  end

  // R2: a processor strobe never yields a write
  a_r2_proc_reads: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && selected) |-> (str.doRead && !str.doWrite));

  // R3: controller strobe and write inputs ignored under processor strobe
  a_r3_ctl_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !ctlStrobeN && !gwN) |-> (byteWe == '0));

  // R1: deselect closes the session
  a_r1_desel_ends: assert property (@(posedge clk) disable iff (!rstN)
    ((!procStrobeN || !ctlStrobeN) && !selected) |=> !sessionActive);

  // R6: a lane strobe only inside a write cycle
  a_r6_lane_in_write: assert property (@(posedge clk) disable iff (!rstN)
    (byteWe != '0) |-> str.doWrite);

  // R7: continuation only after an accepted start
  a_r7_cont_needs_session: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobeN && ctlStrobeN && !sessionActive) |-> (!str.doRead && !str.doWrite));

endmodule

// File: rtl/sram_fe_dp.sv
module sram_fe_dp
  import sram_fe_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobes_t                    str,
  input  logic [NUM_BYTES-1:0]        byteWe,
  input  logic                        oeN,
  input  logic [ADDR_W-1:0]           addrIn,
  input  logic [NUM_BYTES*BYTE_W-1:0] dataIn,
  output logic [NUM_BYTES*BYTE_W-1:0] dataOut,
  output logic [NUM_BYTES-1:0]        byteOe
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = NUM_BYTES * BYTE_W;

  logic [DATA_W-1:0] memArray [DEPTH];
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] accessAddr;
  logic [DATA_W-1:0] rdReg;
  logic              rdValid;

  assign accessAddr = str.loadAddr ? addrIn : addrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (str.loadAddr) begin
      addrReg <= addrIn;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (byteWe[i]) begin
        memArray[accessAddr][i*BYTE_W +: BYTE_W] <= dataIn[i*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdReg   <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= str.doRead;
      if (str.doRead) begin
        rdReg <= memArray[accessAddr];
      end
    end
  end

  assign dataOut = rdReg;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : gOe
    assign byteOe[i] = rdValid && !oeN && !str.doWrite;
  end

  // R8: address register holds outside start cycles
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !str.loadAddr |=> $stable(addrReg));

  // R8: start cycles capture the presented address
  a_r8_addr_load: assert property (@(posedge clk) disable iff (!rstN)
    str.loadAddr |=> (addrReg == $past(addrIn)));

  // R9: bus never driven while a write is decoded
  a_r9_oe_off_in_write: assert property (@(posedge clk) disable iff (!rstN)
    str.doWrite |-> (byteOe == '0));

  // R9: lanes switch together
  a_r9_oe_uniform: assert property (@(posedge clk) disable iff (!rstN)
    (byteOe == '0) || (byteOe == '1));

  // R2: a read cycle is followed by a valid data phase
  a_r2_data_phase: assert property (@(posedge clk) disable iff (!rstN)
    str.doRead |=> rdValid);

endmodule

// File: rtl/burst_sram_front.sv
module burst_sram_front
  import sram_fe_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        ce1N,
  input  logic                        ce2,
  input  logic                        ce3N,
  input  logic                        procStrobeN,
  input  logic                        ctlStrobeN,
  input  logic                        gwN,
  input  logic                        bweN,
  input  logic [NUM_BYTES-1:0]        bwN,
  input  logic                        oeN,
  input  logic [ADDR_W-1:0]           addrIn,
  input  logic [NUM_BYTES*BYTE_W-1:0] dataIn,
  output logic [NUM_BYTES*BYTE_W-1:0] dataOut,
  output logic [NUM_BYTES-1:0]        byteOe
);

  strobes_t             str;
  logic [NUM_BYTES-1:0] byteWe;

  sram_fe_ctl #(.NUM_BYTES(NUM_BYTES)) uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .ce1N        (ce1N),
    .ce2         (ce2),
    .ce3N        (ce3N),
    .procStrobeN (procStrobeN),
    .ctlStrobeN  (ctlStrobeN),
    .gwN         (gwN),
    .bweN        (bweN),
    .bwN         (bwN),
    .str         (str),
    .byteWe      (byteWe)
  );

  sram_fe_dp #(
    .ADDR_W    (ADDR_W),
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .str     (str),
    .byteWe  (byteWe),
    .oeN     (oeN),
    .addrIn  (addrIn),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .byteOe  (byteOe)
  );

endmodule

// File: tb/sim_burst_sram_front.sv
`timescale 1ns/1ps
module sim_burst_sram_front;

  localparam int AW = 6;
  localparam int BW = 8;
  localparam int NB = 2;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic          ce1N, ce2, ce3N, procStrobeN, ctlStrobeN, gwN, bweN, oeN;
  logic [NB-1:0] bwN;
  logic [AW-1:0] addrIn;
  logic [DW-1:0] dataIn;
  logic [DW-1:0] dataOut;
  logic [NB-1:0] byteOe;

  int total = 0;
  int bad   = 0;

  logic [DW-1:0] mMem [DEPTH];
  logic [AW-1:0] mAddr;
  logic          mSession;
  logic          mRdValid;
  logic [DW-1:0] mRdData;
  string         mRdTag;

  always #2 clk = ~clk;

  burst_sram_front #(.ADDR_W(AW), .BYTE_W(BW), .NUM_BYTES(NB)) u0 (
    .clk(clk), .rstN(rstN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .procStrobeN(procStrobeN), .ctlStrobeN(ctlStrobeN), .gwN(gwN),
    .bweN(bweN), .bwN(bwN), .oeN(oeN), .addrIn(addrIn), .dataIn(dataIn),
    .dataOut(dataOut), .byteOe(byteOe)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic isSel();
    return !ce1N && ce2 && !ce3N;
  endfunction

  function automatic logic wrTerm();
    return !gwN || (!bweN && (|(~bwN)));
  endfunction

  function automatic logic [NB-1:0] laneMask();
    logic [NB-1:0] m;
    for (int i = 0; i < NB; i++) m[i] = !gwN || (!bweN && !bwN[i]);
    return m;
  endfunction

  // 0 idle, 1 desel, 2 read start, 3 write start, 4 cont read, 5 cont write
  function automatic int cycKind();
    if (!procStrobeN) return isSel() ? 2 : 1;
    if (!ctlStrobeN)  return !isSel() ? 1 : (wrTerm() ? 3 : 2);
    if (mSession)     return wrTerm() ? 5 : 4;
    return 0;
  endfunction

  function automatic logic [NB-1:0] expOe();
    int k = cycKind();
    logic on = mRdValid && !oeN && !(k == 3 || k == 5);
    return on ? '1 : '0;
  endfunction

  task automatic setIdle();
    ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0;
    procStrobeN = 1'b1; ctlStrobeN = 1'b1;
    gwN = 1'b1; bweN = 1'b1; bwN = '1; oeN = 1'b0;
    addrIn = '0; dataIn = '0;
  endtask

  // Called at a falling edge with inputs already set; returns at the next falling edge.
  task automatic doCycle(string oeTag);
    int k;
    logic [AW-1:0] a;
    #1;
    check(oeTag, {30'd0, byteOe}, {30'd0, expOe()});
    @(posedge clk);
    k = cycKind();
    a = (k == 2 || k == 3) ? addrIn : mAddr;
    if (k == 3 || k == 5) begin
      for (int i = 0; i < NB; i++)
        if (laneMask()[i]) mMem[a][i*BW +: BW] = dataIn[i*BW +: BW];
    end
    mRdValid = (k == 2 || k == 4);
    if (mRdValid) begin
      mRdData = mMem[a];
      mRdTag  = (k == 2) ? "R2" : "R7";
    end
    if (k == 1) mSession = 1'b0;
    else if (k == 2 || k == 3) mSession = 1'b1;
    if (k == 2 || k == 3) mAddr = addrIn;
    @(negedge clk);
    if (mRdValid) check(mRdTag, {16'd0, dataOut}, {16'd0, mRdData});
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    mSession = 1'b0; mRdValid = 1'b0; mRdData = '0; mAddr = '0; mRdTag = "R2";
    setIdle();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", {30'd0, byteOe}, 32'd0);
    rstN = 1'b1;

    // Fill the array through controller-strobe global writes (R4, R5)
    for (int a = 0; a < DEPTH; a++) begin
      setIdle(); ctlStrobeN = 1'b0; gwN = 1'b0;
      addrIn = AW'(a); dataIn = DW'($urandom);
      doCycle("R9");
    end

    // R3: processor strobe with write inputs and controller strobe is a read
    setIdle(); procStrobeN = 1'b0; ctlStrobeN = 1'b0; gwN = 1'b0;
    addrIn = 6'd5; dataIn = 16'hDEAD;
    doCycle("R3");
    check("R3", {16'd0, dataOut}, {16'd0, mMem[5]});
    setIdle();
    check("R9", {30'd0, byteOe}, 32'h3);
    oeN = 1'b1; #1;
    check("R9", {30'd0, byteOe}, 32'd0);

    // R6: lane 1 only, via byte-write enable
    setIdle(); ctlStrobeN = 1'b0; bweN = 1'b0; bwN = 2'b01;
    addrIn = 6'd9; dataIn = 16'hA55A;
    doCycle("R9");
    setIdle(); procStrobeN = 1'b0; addrIn = 6'd9;
    doCycle("R6");
    check("R6", {16'd0, dataOut}, {16'd0, mMem[9]});

    // R5: bweN high with lane enables low is not a write; controller strobe reads
    setIdle(); ctlStrobeN = 1'b0; bwN = 2'b00; addrIn = 6'd9; dataIn = 16'h1111;
    doCycle("R5");
    check("R5", {16'd0, dataOut}, {16'd0, mMem[9]});

    // R7/R8: continuation write then read at held address while addrIn moves
    setIdle(); procStrobeN = 1'b0; addrIn = 6'd20;
    doCycle("R9");
    setIdle(); gwN = 1'b0; addrIn = 6'd33; dataIn = 16'hBEEF; oeN = 1'b0;
    doCycle("R9");
    check("R9", {30'd0, byteOe}, 32'd0);
    setIdle(); addrIn = 6'd40;
    doCycle("R8");
    check("R8", {16'd0, dataOut}, 32'h0000BEEF);

    // R1: deselect via each chip select, then outputs stay off
    setIdle(); procStrobeN = 1'b0; ce2 = 1'b0; addrIn = 6'd3;
    doCycle("R1");
    setIdle();
    check("R1", {30'd0, byteOe}, 32'd0);
    ctlStrobeN = 1'b0; ce3N = 1'b1; gwN = 1'b0; dataIn = 16'h7777; addrIn = 6'd3;
    doCycle("R1");
    setIdle(); ce1N = 1'b1;
    doCycle("R7");
    check("R1", {30'd0, byteOe}, 32'd0);
    setIdle(); procStrobeN = 1'b0; addrIn = 6'd3;
    doCycle("R1");
    check("R1", {16'd0, dataOut}, {16'd0, mMem[3]});

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      setIdle();
      r = $urandom_range(0, 9);
      procStrobeN = (r == 0);
      procStrobeN = !(r < 2);
      ctlStrobeN  = !(r >= 2 && r < 5);
      ce1N = ($urandom_range(0, 9) == 0);
      ce2  = ($urandom_range(0, 9) != 0);
      ce3N = ($urandom_range(0, 9) == 0);
      gwN  = ($urandom_range(0, 4) != 0);
      bweN = ($urandom_range(0, 1) != 0);
      bwN  = NB'($urandom);
      oeN  = ($urandom_range(0, 3) == 0);
      addrIn = AW'($urandom);
      dataIn = DW'($urandom);
      doCycle("R9");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule